// File: doc/BRIEF.md
# Loop Table Fetch Bypass Controller

This block sits on the instruction fetch path between a small processor and its program ROM. Leaving reset, it reads one loop descriptor from a tiny configuration store. The descriptor holds a valid flag, the loop's first address and its last address. When the descriptor is usable, the block copies that address range out of ROM into a local loop table and turns its bypass on. From then on, every fetch whose address falls inside the stored range is answered from the table, and the ROM stays idle on that cycle. Every other fetch goes to ROM as usual.

The table is indexed by the fetch address minus the loop start, so it carries no tags and cannot miss. Both paths return the instruction in the same cycle, so the processor sees exactly the same instruction stream and timing either way. Each table entry holds one precomputed exit bit, which is set only on the last loop instruction. When the processor fetches that entry, the block raises a flag telling it that the next fetch leaves the table unless a backward branch is taken. The processor is held not-ready until the preload is finished.

The controller is a state machine with these states:
- `LD_FLAG`, `LD_START` and `LD_END` read configuration words 0, 1 and 2, one per cycle, always advancing.
- `LD_CHECK` moves to `LD_COPY` when the descriptor is usable and to `RUN_ROM` when it is not.
- `LD_COPY` stays put until the last loop word has been copied, then moves to `RUN_TABLE`.
- `RUN_TABLE` and `RUN_ROM` hold until the next reset.

Top module: `loop_fetch_bypass`

## Requirements
- R1: After reset release, `cpu_ready` stays low for 4 + L cycles when a loop of L words is loaded, and for exactly 4 cycles when the descriptor is rejected. Once high, it stays high. During reset, `cpu_ready`, `rom_en` and `cpu_from_table` are all low.
- R2: The descriptor is read from configuration addresses 0 (bit 0 = valid flag), 1 (loop start address) and 2 (loop end address).
- R3: A descriptor is rejected when its flag bit is 0, when end < start, or when end - start + 1 exceeds the table depth (32). After a rejection, no fetch is ever served from the table.
- R4: With the bypass on and cpu_req high, a fetch address in [start, end] returns the word that ROM held at that address during the preload. In that cycle `cpu_from_table` is 1 and `rom_en` is 0.
- R5: A fetch outside the loop, or any fetch while the bypass is off, returns the current `rom_rdata` combinationally. `rom_addr` equals `cpu_addr`, `rom_en` equals `cpu_req`, and `cpu_from_table` is 0.
- R6: `cpu_loop_exit` is 1 only when a fetch is served from the table at the loop end address.
- R7: During the preload, `rom_en` is 1 for exactly L cycles, and `rom_addr` walks start, start+1, … end, one step per cycle.
- R8: While `cpu_req` is low after the preload, `rom_en` is low and nothing is served from the table.
- R9: A loop of exactly 32 words, and a loop of a single word, are both accepted and served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | output | 2 | Configuration word address |
| cfg_rdata | input | 12 | Configuration word (combinational read) |
| rom_addr | output | 12 | ROM address |
| rom_en | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM data (combinational read) |
| cpu_req | input | 1 | Processor fetch request |
| cpu_addr | input | 12 | Processor fetch address |
| cpu_instr | output | 8 | Instruction returned to the processor |
| cpu_ready | output | 1 | Preload finished; fetches are valid |
| cpu_from_table | output | 1 | Current fetch is served by the loop table |
| cpu_loop_exit | output | 1 | Current fetch is the last loop instruction |

## Verification
Once the preload is done, the bench changes the ROM contents, so a table hit can be told apart from a ROM read by its data as well as by `rom_en`. The bench fetches addresses just below, at, inside and just past the loop, plus the extremes of the address space. This separates off-by-one errors in the range compare from errors in the index arithmetic. Descriptors are tried with:
- the flag cleared,
- end before start,
- a span one word over the depth,
- a span of exactly the depth,
- a single-word span.

Between them these separate the acceptance rule, the preload length and the exit-bit placement.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic [2:0] {
        LD_FLAG,
        LD_START,
        LD_END,
        LD_CHECK,
        LD_COPY,
        RUN_TABLE,
        RUN_ROM
    } lbc_state_e;

    localparam logic [1:0] CFG_FLAG_WORD  = 2'd0;
    localparam logic [1:0] CFG_START_WORD = 2'd1;
    localparam logic [1:0] CFG_END_WORD   = 2'd2;
endpackage

// File: rtl/lbc_loader.sv
module lbc_loader
    import lbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_rdata,
    output logic [ADDR_W-1:0] ld_addr,
    output logic              ld_rd,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_last,
    output logic [ADDR_W-1:0] loop_start,
    output logic [ADDR_W-1:0] loop_end,
    output logic              bypass_on,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    lbc_state_e        state_q, state_d;
    logic              flag_q;
    logic [ADDR_W-1:0] start_q, end_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] span;
    logic              cfg_good;
    logic              last;

    assign span     = end_q - start_q;
    assign cfg_good = flag_q && (end_q >= start_q) && (span < DEPTH_A);
    assign last     = (cnt_q == span[IDX_W-1:0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_FLAG;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_FLAG:   state_d = LD_START;
            LD_START:  state_d = LD_END;
            LD_END:    state_d = LD_CHECK;
            LD_CHECK:  state_d = cfg_good ? LD_COPY : RUN_ROM;
            LD_COPY:   state_d = last ? RUN_TABLE : LD_COPY;
            RUN_TABLE: state_d = RUN_TABLE;
            RUN_ROM:   state_d = RUN_ROM;
            default:   state_d = LD_FLAG;
        endcase
    end

    // descriptor and copy counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (state_q == LD_FLAG)  flag_q  <= cfg_rdata[0];
            if (state_q == LD_START) start_q <= cfg_rdata;
            if (state_q == LD_END)   end_q   <= cfg_rdata;
            if (state_q == LD_COPY && !last) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cfg_addr  = CFG_FLAG_WORD;
        ld_rd     = 1'b0;
        wr_en     = 1'b0;
        bypass_on = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            LD_FLAG:   cfg_addr = CFG_FLAG_WORD;
            LD_START:  cfg_addr = CFG_START_WORD;
            LD_END:    cfg_addr = CFG_END_WORD;
            LD_CHECK:  cfg_addr = CFG_FLAG_WORD;
            LD_COPY: begin
                ld_rd = 1'b1;
                wr_en = 1'b1;
            end
            RUN_TABLE: begin
                bypass_on = 1'b1;
                ready     = 1'b1;
            end
            RUN_ROM:   ready = 1'b1;
            default:   cfg_addr = CFG_FLAG_WORD;
        endcase
    end

    assign ld_addr    = start_q + ADDR_W'(cnt_q);
    assign wr_idx     = cnt_q;
    assign wr_last    = last;
    assign loop_start = start_q;
    assign loop_end   = end_q;

    // R7: consecutive copy cycles step the ROM address by one
    p_copy_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_COPY && $past(state_q) == LD_COPY)
            |-> ld_addr == $past(ld_addr) + ADDR_W'(1));

    // R3: the table is only in use for a span that fits
    p_span_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_TABLE) |-> (flag_q && end_q >= start_q && span < DEPTH_A));

    // R1: once ready, stays ready
    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/lbc_table.sv
module lbc_table #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_exit
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  exit_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     exit_q <= '0;
        else if (wr_en) exit_q[wr_idx] <= wr_last;
    end

    assign rd_data = mem[rd_idx];
    assign rd_exit = exit_q[rd_idx];

    // R6: at most one entry marks the loop end
    p_one_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exit_q));
endmodule

// File: rtl/lbc_select.sv
module lbc_select #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              bypass_on,
    input  logic [ADDR_W-1:0] loop_start,
    input  logic [ADDR_W-1:0] loop_end,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] tbl_data,
    input  logic              tbl_exit,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              hit,
    output logic [DATA_W-1:0] instr,
    output logic              at_exit
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;

    assign offset   = cpu_addr - loop_start;
    assign rd_idx   = offset[IDX_W-1:0];
    assign in_range = (cpu_addr >= loop_start) && (cpu_addr <= loop_end);
    assign hit      = bypass_on && cpu_req && in_range;
    assign instr    = hit ? tbl_data : rom_rdata;
    assign at_exit  = hit && tbl_exit;
endmodule

// File: rtl/loop_fetch_bypass.sv
module loop_fetch_bypass #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_en,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_instr,
    output logic              cpu_ready,
    output logic              cpu_from_table,
    output logic              cpu_loop_exit
);
    logic [ADDR_W-1:0] ld_addr, loop_start, loop_end;
    logic              ld_rd, wr_en, wr_last, bypass_on, hit;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] tbl_data;
    logic              tbl_exit;

    lbc_loader #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) loader_i (
        .clk, .rst_n, .cfg_addr, .cfg_rdata,
        .ld_addr, .ld_rd, .wr_en, .wr_idx, .wr_last,
        .loop_start, .loop_end, .bypass_on, .ready(cpu_ready)
    );

    lbc_table #(.DATA_W(DATA_W), .DEPTH(DEPTH)) table_i (
        .clk, .rst_n, .wr_en, .wr_idx, .wr_data(rom_rdata), .wr_last,
        .rd_idx, .rd_data(tbl_data), .rd_exit(tbl_exit)
    );

    lbc_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) select_i (
        .bypass_on, .loop_start, .loop_end, .cpu_req, .cpu_addr,
        .tbl_data, .tbl_exit, .rom_rdata,
        .rd_idx, .hit, .instr(cpu_instr), .at_exit(cpu_loop_exit)
    );

    assign rom_addr       = cpu_ready ? cpu_addr : ld_addr;
    assign rom_en         = ld_rd | (cpu_ready & cpu_req & ~hit);
    assign cpu_from_table = hit;

    // R4: a table-served fetch leaves the ROM idle
    p_tbl_rom_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_from_table |-> !rom_en);

    // R6: the exit flag only appears on table-served fetches
    p_exit_in_tbl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_loop_exit |-> cpu_from_table);

    // R1: nothing is served before the preload finishes
    p_no_tbl_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> !cpu_from_table);

    // R8: no request, no ROM access after preload
    p_noreq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_req) |-> !rom_en);
endmodule

// File: tb/loop_fetch_bypass_tb_top.sv
module loop_fetch_bypass_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_addr;
    logic [11:0] cfg_rdata;
    logic [11:0] rom_addr;
    logic        rom_en;
    logic [7:0]  rom_rdata;
    logic        cpu_req = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  cpu_instr;
    logic        cpu_ready, cpu_from_table, cpu_loop_exit;

    logic        cfg_flag = 1'b0;
    logic [11:0] cfg_start = '0, cfg_end = '0;
    logic [7:0]  rom_mask = '0;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [11:0] a);
        return (a[7:0] * 8'd13 + {4'h0, a[11:8]}) ^ 8'hA5;
    endfunction

    always_comb begin
        case (cfg_addr)
            2'd0:    cfg_rdata = {11'h0, cfg_flag};
            2'd1:    cfg_rdata = cfg_start;
            2'd2:    cfg_rdata = cfg_end;
            default: cfg_rdata = 12'hFFF;
        endcase
    end
    assign rom_rdata = rom_fn(rom_addr) ^ rom_mask;

    loop_fetch_bypass dut_i (
        .clk, .rst_n, .cfg_addr, .cfg_rdata, .rom_addr, .rom_en, .rom_rdata,
        .cpu_req, .cpu_addr, .cpu_instr, .cpu_ready, .cpu_from_table, .cpu_loop_exit
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reset, then preload; exp_len = 0 means the descriptor must be rejected
    task automatic do_load(input bit f, input logic [11:0] s, input logic [11:0] e,
                           input int exp_len);
        int cyc, k;
        cyc = 0;
        k = 0;
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 1'b0; rom_mask = 8'h00;
        cfg_flag = f; cfg_start = s; cfg_end = e;
        repeat (2) @(negedge clk);
        chk(!cpu_ready && !rom_en && !cpu_from_table, "R1 reset state",
            {cpu_ready, rom_en, cpu_from_table}, 0);
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            if (!cpu_ready && rom_en) begin
                chk(rom_addr == s + 12'(k), "R7 preload address", rom_addr, s + 12'(k));
                k++;
            end
        end while (!cpu_ready && cyc < 100);
        chk(cyc == 4 + exp_len, "R1 ready delay (R2 descriptor order)", cyc, 4 + exp_len);
        chk(k == exp_len, "R7 preload length", k, exp_len);
        rom_mask = 8'h5A;
    endtask

    // one fetch; exp_tbl says whether the table must serve it
    task automatic fetch(input logic [11:0] a, input bit exp_tbl,
                         input logic [11:0] loop_last, input string req);
        logic [7:0] exp_i;
        cpu_req = 1'b1;
        cpu_addr = a;
        #1;
        exp_i = exp_tbl ? rom_fn(a) : (rom_fn(a) ^ rom_mask);
        chk(cpu_from_table == exp_tbl, req, cpu_from_table, exp_tbl);
        chk(rom_en == !exp_tbl, req, rom_en, !exp_tbl);
        chk(cpu_instr == exp_i, req, cpu_instr, exp_i);
        chk(cpu_loop_exit == (exp_tbl && a == loop_last), "R6 exit flag",
            cpu_loop_exit, exp_tbl && a == loop_last);
        if (!exp_tbl)
            chk(rom_addr == a, "R5 rom address", rom_addr, a);
        @(negedge clk);
    endtask

    // bit 12: fetch must come from the table; loop 0x040..0x04F
    localparam logic [12:0] VEC [12] = '{
        13'h0_03F, 13'h1_040, 13'h1_041, 13'h1_047, 13'h1_04E, 13'h1_04F,
        13'h0_050, 13'h0_000, 13'h0_FFF, 13'h1_04F, 13'h1_040, 13'h0_140
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // main loop 0x040..0x04F, 16 words
        do_load(1'b1, 12'h040, 12'h04F, 16);
        for (int i = 0; i < 12; i++)
            fetch(VEC[i][11:0], VEC[i][12], 12'h04F, VEC[i][12] ? "R4 table fetch" : "R5 rom fetch");

        // R8: no request
        cpu_req = 1'b0; cpu_addr = 12'h044; #1;
        chk(!rom_en && !cpu_from_table, "R8 idle inside loop", {rom_en, cpu_from_table}, 0);
        cpu_addr = 12'h010; #1;
        chk(!rom_en, "R8 idle outside loop", rom_en, 0);
        @(negedge clk);

        // R3: flag cleared
        do_load(1'b0, 12'h040, 12'h04F, 0);
        fetch(12'h044, 1'b0, 12'h04F, "R3 flag cleared");
        // R3: end before start
        do_load(1'b1, 12'h050, 12'h040, 0);
        fetch(12'h048, 1'b0, 12'h040, "R3 reversed range");
        // R3: 33 words
        do_load(1'b1, 12'h100, 12'h120, 0);
        fetch(12'h100, 1'b0, 12'h120, "R3 oversize span");

        // R9: exactly 32 words
        do_load(1'b1, 12'h100, 12'h11F, 32);
        fetch(12'h100, 1'b1, 12'h11F, "R9 full table first");
        fetch(12'h11F, 1'b1, 12'h11F, "R9 full table last");
        fetch(12'h120, 1'b0, 12'h11F, "R9 full table past end");
        // R9: single word
        do_load(1'b1, 12'h200, 12'h200, 1);
        fetch(12'h200, 1'b1, 12'h200, "R9 single word");
        fetch(12'h201, 1'b0, 12'h200, "R9 single word next");
        fetch(12'h1FF, 1'b0, 12'h200, "R9 single word before");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule